// File: doc/BRIEF.md
# Memory-Side Page Translator with Two-Level Table Walker

This block sits on the memory side of a translation buffer that has been split across two chips. The processor side keeps only the virtual page tags. On a hit it sends a short slot index together with the in-page offset, instead of a full page number. This block holds the matching physical page numbers in a 64-slot file. On a hit it rebuilds the full real address by joining the stored page number with the offset it received.

When the processor side misses, it raises a miss line and sends the virtual page number in pieces over the same offset lines, one piece per transfer:

- The first transfer carries the first-level table offset.
- The second transfer carries the second-level table offset, with the slot to refill on the index lines.
- The third transfer carries the page offset.

Each piece launches its table read as soon as the data it needs has arrived, so the walk overlaps the serial transfer. The resulting page number is written into the named slot, driven out as the real address, and returned on a separate output so that the processor side can complete its own refill. A table entry whose valid bit is clear raises a fault instead.

Top module: `split_tlb_memside`

## Requirements
- R1: When `xfer_valid` is high, `miss_in` is low and no walk is in progress, then one cycle later `pa_valid` is high, `ppn_valid` is low, and `pa_addr` equals {slot[`idx_in`], `off_in`}.
- R2: A cycle with `root_load` high stores `root_frame` as the first-level table frame. Every later walk reads its first-level entry at {root frame, `off_in`[9:0], 2'b00}.
- R3: A walk starts when `xfer_valid` and `miss_in` are both high while idle; that transfer's `off_in`[9:0] is the first-level offset. Exactly one single-cycle `mem_req` pulse is made for each table read.
- R4: The second read is issued only after the first-level entry has returned with `mem_rvalid` and the second transfer has arrived. Its address is {entry[31:12], second `off_in`[9:0], 2'b00}.
- R5: Once the second-level entry is valid and the third transfer has arrived, the block pulses `pa_valid` and `ppn_valid` for one cycle. At that point `pa_addr` is {entry[31:12], third `off_in`} and `ppn_out` is entry[31:12].
- R6: The new page number is written into the slot given by `idx_in` on the second transfer, and a later hit on that slot returns it.
- R7: Bit 0 of every table entry is its valid bit. A clear valid bit in either level gives a one-cycle `fault` pulse, no `ppn_valid`, and leaves the slot file unchanged.
- R8: While a walk is in progress, transfers (sent with `miss_in` low) are consumed as walk pieces and never produce a hit result. The block accepts a new request only after the third piece has been received.
- R9: The walker waits any number of cycles for `mem_rvalid`. Gaps between transfers do not change the result.
- R10: During and just after reset, `pa_valid`, `ppn_valid`, `fault` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | A transfer is present on the index and offset lines |
| miss_in | input | 1 | Marks the first transfer of a miss |
| idx_in | input | 6 | Slot index (hit) or replacement slot (second miss transfer) |
| off_in | input | 12 | Page offset or table offset |
| root_load | input | 1 | Load the first-level table frame |
| root_frame | input | 20 | First-level table frame number |
| mem_req | output | 1 | Table read request pulse |
| mem_addr | output | 32 | Table read byte address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 32 | Table entry: [31:12] frame, [0] valid |
| pa_valid | output | 1 | Real address valid |
| pa_addr | output | 32 | Real address |
| ppn_valid | output | 1 | Page number returned for a refill |
| ppn_out | output | 20 | Refilled page number |
| fault | output | 1 | Invalid table entry found |

## Verification
The embedded assertions check on every cycle that:

- table reads are single-cycle pulses;
- the slot file is written at most once per walk, never after a fault, and never from an unknown index;
- an idle hit request always yields a hit result one cycle later;
- transfers taken during a walk never yield one.

Only the bench scenarios can show the data relations: the computed read addresses, the joined real addresses, that a refilled slot reads back on a later hit, that a fault leaves the old contents in place, that a newly loaded root frame is used, and that results do not change with memory latency or transfer gaps.

// File: rtl/mtlb_pkg.sv
package mtlb_pkg;
  typedef enum logic [2:0] {
    W_IDLE      = 3'd0,
    W_RD_BASE   = 3'd1,
    W_RD_SECOND = 3'd2,
    W_FILL      = 3'd3,
    W_DONE      = 3'd4
  } walk_state_t;
endpackage

// File: rtl/pfn_file.sv
module pfn_file #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6,
  parameter int DAT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DAT_W-1:0] rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DAT_W-1:0] wr_data
);
  logic [DAT_W-1:0] slots [DEPTH];
  logic [DAT_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_idx] <= wr_data;
    if (rd_en) rd_q <= slots[rd_idx];
  end

  assign rd_data = rd_q;

  // R6: a refill always targets a known slot
  a_r6_write_idx_known: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$isunknown(wr_idx));
endmodule

// File: rtl/hit_stage.sv
module hit_stage #(
  parameter int OFF_W = 12,
  parameter int PPN_W = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hit_req,
  input  logic [OFF_W-1:0]       off_in,
  input  logic [PPN_W-1:0]       rd_data,
  output logic                   hit_valid,
  output logic [PPN_W+OFF_W-1:0] hit_addr
);
  logic             v_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= hit_req;
    if (hit_req) off_q <= off_in;
  end

  assign hit_valid = v_q;
  assign hit_addr  = {rd_data, off_q};

  // R1: the offset register never goes stale under a result
  a_r1_off_captured: assert property (@(posedge clk) disable iff (rst)
    hit_req |=> $past(off_in) == off_q);
endmodule

// File: rtl/walk_engine.sv
module walk_engine
  import mtlb_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 xfer_valid,
  input  logic                 miss_in,
  input  logic [IDX_W-1:0]     idx_in,
  input  logic [OFF_W-1:0]     off_in,
  input  logic [PA_W-OFF_W-1:0] root_q,
  output logic                 mem_req,
  output logic [PA_W-1:0]      mem_addr,
  input  logic                 mem_rvalid,
  input  logic [PA_W-1:0]      mem_rdata,
  output logic                 wr_en,
  output logic [IDX_W-1:0]     wr_idx,
  output logic [PA_W-OFF_W-1:0] wr_ppn,
  output logic                 busy,
  output logic                 fill_valid,
  output logic [PA_W-1:0]      fill_addr,
  output logic                 fault
);
  localparam int PPN_W = PA_W - OFF_W;
  localparam int LVL_W = OFF_W - 2;

  walk_state_t      state;
  logic             have_lvl2, have_pgoff, issued, fault_seen;
  logic [LVL_W-1:0] lvl2_q;
  logic [IDX_W-1:0] repl_q;
  logic [OFF_W-1:0] pgoff_q;
  logic [PPN_W-1:0] sec_frame_q, ppn_q;
  logic             entry_ok;
  logic             unused_rdata;

  assign entry_ok     = mem_rdata[0];
  assign unused_rdata = ^mem_rdata[OFF_W-1:1];
  assign busy         = (state != W_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= W_IDLE;
      have_lvl2  <= 1'b0;
      have_pgoff <= 1'b0;
      issued     <= 1'b0;
      fault_seen <= 1'b0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      wr_en      <= 1'b0;
      fill_valid <= 1'b0;
      fault      <= 1'b0;
    end else begin
      mem_req    <= 1'b0;
      wr_en      <= 1'b0;
      fill_valid <= 1'b0;
      fault      <= 1'b0;
      // serial pieces that follow the first transfer
      if (state != W_IDLE && xfer_valid) begin
        if (!have_lvl2) begin
          lvl2_q    <= off_in[LVL_W-1:0];
          repl_q    <= idx_in;
          have_lvl2 <= 1'b1;
        end else if (!have_pgoff) begin
          pgoff_q    <= off_in;
          have_pgoff <= 1'b1;
        end
      end
      case (state)
        W_IDLE: begin
          have_lvl2  <= 1'b0;
          have_pgoff <= 1'b0;
          issued     <= 1'b0;
          if (xfer_valid && miss_in) begin
            mem_req    <= 1'b1;
            mem_addr   <= {root_q, off_in[LVL_W-1:0], 2'b00};
            fault_seen <= 1'b0;
            state      <= W_RD_BASE;
          end
        end
        W_RD_BASE: begin
          if (mem_rvalid) begin
            if (!entry_ok) begin
              fault      <= 1'b1;
              fault_seen <= 1'b1;
              state      <= W_DONE;
            end else begin
              sec_frame_q <= mem_rdata[PA_W-1:OFF_W];
              state       <= W_RD_SECOND;
            end
          end
        end
        W_RD_SECOND: begin
          if (!issued && have_lvl2) begin
            mem_req  <= 1'b1;
            mem_addr <= {sec_frame_q, lvl2_q, 2'b00};
            issued   <= 1'b1;
          end else if (issued && mem_rvalid) begin
            if (!entry_ok) begin
              fault      <= 1'b1;
              fault_seen <= 1'b1;
              state      <= W_DONE;
            end else begin
              ppn_q <= mem_rdata[PA_W-1:OFF_W];
              state <= W_FILL;
            end
          end
        end
        W_FILL: begin
          if (have_pgoff) begin
            wr_en      <= 1'b1;
            wr_idx     <= repl_q;
            wr_ppn     <= ppn_q;
            fill_valid <= 1'b1;
            fill_addr  <= {ppn_q, pgoff_q};
            state      <= W_DONE;
          end
        end
        W_DONE: begin
          if (have_lvl2 && have_pgoff) state <= W_IDLE;
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  // R3: each table read is a single-cycle pulse
  a_r3_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R7: no refill once a walk has faulted
  a_r7_no_fill_after_fault: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !fault_seen);

  // R6: at most one slot write per walk
  a_r6_single_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R7: a fault never coincides with a returned page number
  a_r7_fault_excl: assert property (@(posedge clk) disable iff (rst)
    fault |-> !fill_valid);
endmodule

// File: rtl/split_tlb_memside.sv
module split_tlb_memside #(
  parameter int DEPTH = 64,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_valid,
  input  logic             miss_in,
  input  logic [IDX_W-1:0] idx_in,
  input  logic [OFF_W-1:0] off_in,
  input  logic             root_load,
  input  logic [PPN_W-1:0] root_frame,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [PA_W-1:0]  mem_rdata,
  output logic             pa_valid,
  output logic [PA_W-1:0]  pa_addr,
  output logic             ppn_valid,
  output logic [PPN_W-1:0] ppn_out,
  output logic             fault
);
  logic [PPN_W-1:0] root_q;
  logic             busy, hit_req, hit_valid;
  logic [PA_W-1:0]  hit_addr, fill_addr;
  logic [PPN_W-1:0] rd_data, wr_ppn;
  logic             wr_en, fill_valid;
  logic [IDX_W-1:0] wr_idx;

  always_ff @(posedge clk) begin
    if (rst)            root_q <= '0;
    else if (root_load) root_q <= root_frame;
  end

  assign hit_req = xfer_valid && !miss_in && !busy;

  pfn_file #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DAT_W(PPN_W)) u_file (
    .clk(clk), .rst(rst),
    .rd_en(hit_req), .rd_idx(idx_in), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_ppn)
  );

  hit_stage #(.OFF_W(OFF_W), .PPN_W(PPN_W)) u_hit (
    .clk(clk), .rst(rst), .hit_req(hit_req), .off_in(off_in),
    .rd_data(rd_data), .hit_valid(hit_valid), .hit_addr(hit_addr)
  );

  walk_engine #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_walk (
    .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .miss_in(miss_in),
    .idx_in(idx_in), .off_in(off_in), .root_q(root_q),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_ppn(wr_ppn), .busy(busy),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fault(fault)
  );

  assign pa_valid  = hit_valid | fill_valid;
  assign pa_addr   = fill_valid ? fill_addr : hit_addr;
  assign ppn_valid = fill_valid;
  assign ppn_out   = fill_addr[PA_W-1:OFF_W];

  // R1: an idle hit request yields a hit result next cycle
  a_r1_hit_latency: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !miss_in && !busy) |=> (pa_valid && !ppn_valid));

  // R8: transfers taken during a walk never produce a hit result
  a_r8_no_hit_in_walk: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && busy) |=> !hit_valid);

  // R5: walk result and hit result never collide
  a_r5_result_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_valid, fill_valid}));
endmodule

// File: tb/split_tlb_memside_bench.sv
module split_tlb_memside_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        xfer_valid, miss_in, root_load;
  logic [5:0]  idx_in;
  logic [11:0] off_in;
  logic [19:0] root_frame;
  logic        mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        pa_valid, ppn_valid, fault;
  logic [31:0] pa_addr;
  logic [19:0] ppn_out;

  always #2 clk = ~clk;

  split_tlb_memside u_split_tlb_memside (
    .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .miss_in(miss_in),
    .idx_in(idx_in), .off_in(off_in), .root_load(root_load),
    .root_frame(root_frame), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pa_valid(pa_valid),
    .pa_addr(pa_addr), .ppn_valid(ppn_valid), .ppn_out(ppn_out),
    .fault(fault)
  );

  typedef struct {
    int          kind;   // 0 hit, 1 refill, 2 fault
    logic [31:0] pa;
    logic [19:0] ppn;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] rd_q[$];
  logic [31:0] pt_mem [int unsigned];
  logic [19:0] slot_model [64];
  logic [19:0] cur_root;
  int          checks = 0;
  int          errors = 0;
  int          lat = 1;

  function automatic logic [31:0] pt_read(input logic [31:0] a);
    return pt_mem.exists(a) ? pt_mem[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // memory responder: checks each read address, returns after lat cycles
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    forever begin
      @(negedge clk);
      if (!rst && mem_req) begin
        logic [31:0] a;
        a = mem_addr;
        if (rd_q.size() == 0) check(0, "R3 unexpected table read", 64'(a), 64'h0);
        else begin
          logic [31:0] e;
          e = rd_q.pop_front();
          check(a == e, "R4 table read address", 64'(a), 64'(e));
        end
        repeat (lat - 1) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = pt_read(a);
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  // monitor: compares results with the scoreboard queue
  always @(negedge clk) begin
    if (!rst && (pa_valid || fault || ppn_valid)) begin
      if (exp_q.size() == 0) begin
        check(0, "R8 unexpected result", 64'(pa_addr), 64'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.kind == 2) begin
          check(fault && !pa_valid && !ppn_valid, {e.tag, " fault"},
                64'({fault, pa_valid, ppn_valid}), 64'b100);
        end else if (e.kind == 1) begin
          check(pa_valid && ppn_valid && !fault && pa_addr == e.pa,
                {e.tag, " refill address"}, 64'(pa_addr), 64'(e.pa));
          check(ppn_out == e.ppn, {e.tag, " returned page"}, 64'(ppn_out), 64'(e.ppn));
        end else begin
          check(pa_valid && !ppn_valid && !fault && pa_addr == e.pa,
                {e.tag, " hit address"}, 64'(pa_addr), 64'(e.pa));
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      xfer_valid = 1'b0; miss_in = 1'b0; root_load = 1'b0;
    end
  endtask

  task automatic do_hit(input logic [5:0] i, input logic [11:0] o, input string tag);
    exp_t e;
    e.kind = 0; e.pa = {slot_model[i], o}; e.ppn = '0; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    xfer_valid = 1'b1; miss_in = 1'b0; idx_in = i; off_in = o;
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic do_miss(input logic [9:0] b, input logic [9:0] s, input logic [5:0] r,
                         input logic [11:0] po, input int gap, input string tag);
    logic [31:0] a1, a2, e1, e2;
    exp_t e;
    a1 = {cur_root, b, 2'b00};
    e1 = pt_read(a1);
    rd_q.push_back(a1);
    e.tag = tag; e.pa = '0; e.ppn = '0;
    if (!e1[0]) e.kind = 2;
    else begin
      a2 = {e1[31:12], s, 2'b00};
      e2 = pt_read(a2);
      rd_q.push_back(a2);
      if (!e2[0]) e.kind = 2;
      else begin
        e.kind = 1; e.ppn = e2[31:12]; e.pa = {e2[31:12], po};
        slot_model[r] = e2[31:12];
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    xfer_valid = 1'b1; miss_in = 1'b1; idx_in = 6'h3f; off_in = {2'b00, b};
    @(negedge clk);
    xfer_valid = 1'b0; miss_in = 1'b0;
    repeat (gap) @(negedge clk);
    xfer_valid = 1'b1; idx_in = r; off_in = {2'b00, s};
    @(negedge clk);
    xfer_valid = 1'b0;
    repeat (gap) @(negedge clk);
    xfer_valid = 1'b1; idx_in = 6'h15; off_in = po;
    @(negedge clk);
    xfer_valid = 1'b0;
    idle(14);
  endtask

  task automatic load_root(input logic [19:0] f);
    @(negedge clk);
    root_load = 1'b1; root_frame = f;
    @(negedge clk);
    root_load = 1'b0;
    cur_root = f;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; xfer_valid = 1'b0; miss_in = 1'b0; root_load = 1'b0;
    idx_in = '0; off_in = '0; root_frame = '0; cur_root = '0;
    // table contents: first level at frame 0x00100, second level at 0x00200/0x00201
    pt_mem[{20'h00100, 10'd3, 2'b00}]   = {20'h00200, 11'h0, 1'b1};
    pt_mem[{20'h00100, 10'd700, 2'b00}] = {20'h00201, 11'h0, 1'b1};
    pt_mem[{20'h00100, 10'd9, 2'b00}]   = {20'h00202, 11'h0, 1'b0};
    pt_mem[{20'h00200, 10'd5, 2'b00}]   = {20'hABCDE, 11'h0, 1'b1};
    pt_mem[{20'h00200, 10'd6, 2'b00}]   = {20'h12345, 11'h0, 1'b1};
    pt_mem[{20'h00201, 10'd1023, 2'b00}] = {20'h0F00D, 11'h0, 1'b1};
    pt_mem[{20'h00201, 10'd8, 2'b00}]   = {20'h77777, 11'h0, 1'b0};
    pt_mem[{20'h00300, 10'd3, 2'b00}]   = {20'h00201, 11'h0, 1'b1};
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!pa_valid && !ppn_valid && !fault && !mem_req, "R10 outputs in reset",
          64'({pa_valid, ppn_valid, fault, mem_req}), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!pa_valid && !ppn_valid && !fault && !mem_req, "R10 outputs after reset",
          64'({pa_valid, ppn_valid, fault, mem_req}), 64'h0);
    load_root(20'h00100);                               // R2 first root
    do_miss(10'd3, 10'd5, 6'd0, 12'h123, 0, "R5 walk back-to-back");
    do_miss(10'd3, 10'd6, 6'd63, 12'hFFF, 0, "R6 walk to top slot");
    lat = 4;
    do_miss(10'd700, 10'd1023, 6'd17, 12'h000, 3, "R9 slow memory with gaps");
    lat = 1;
    do_miss(10'd3, 10'd5, 6'd40, 12'h800, 5, "R8 gapped pieces");
    do_hit(6'd0, 12'h456, "R1 hit slot 0");
    do_hit(6'd63, 12'hFFF, "R6 refilled slot 63");
    do_hit(6'd17, 12'h001, "R6 refilled slot 17");
    do_hit(6'd40, 12'h000, "R1 hit slot 40");
    idle(3);
    // back-to-back hits on consecutive cycles
    begin
      exp_t e;
      e.kind = 0; e.ppn = '0;
      e.pa = {slot_model[0], 12'h010}; e.tag = "R1 burst a"; exp_q.push_back(e);
      e.pa = {slot_model[63], 12'h020}; e.tag = "R1 burst b"; exp_q.push_back(e);
      @(negedge clk); xfer_valid = 1'b1; miss_in = 1'b0; idx_in = 6'd0;  off_in = 12'h010;
      @(negedge clk); idx_in = 6'd63; off_in = 12'h020;
      @(negedge clk); xfer_valid = 1'b0;
    end
    idle(3);
    // R7 first-level invalid, then second-level invalid; slots must keep old values
    do_miss(10'd9, 10'd0, 6'd0, 12'h555, 0, "R7 first-level invalid");
    do_miss(10'd700, 10'd8, 6'd63, 12'h555, 2, "R7 second-level invalid");
    do_miss(10'd50, 10'd0, 6'd17, 12'h555, 0, "R7 absent entry");
    do_hit(6'd0, 12'h0AA, "R7 slot 0 unchanged");
    do_hit(6'd63, 12'h0BB, "R7 slot 63 unchanged");
    do_hit(6'd17, 12'h0CC, "R7 slot 17 unchanged");
    // R2 new root frame selects a different first-level table
    load_root(20'h00300);
    lat = 2;
    do_miss(10'd3, 10'd1023, 6'd5, 12'h3C3, 1, "R2 new root walk");
    do_hit(6'd5, 12'h111, "R2 refilled slot 5");
    idle(10);
    check(exp_q.size() == 0, "R5 all results seen", 64'(exp_q.size()), 64'h0);
    check(rd_q.size() == 0, "R3 all reads seen", 64'(rd_q.size()), 64'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule